// File: doc/BRIEF.md
# Counting Semaphore Cell

This block is one shared semaphore slot used by several hardware threads to coordinate. It keeps an unsigned count (16 bits by default) and offers several access views, chosen by a 3-bit view code on each request. The two semaphore views implement the classic P (take) and V (give) operations. A read acts as P: it returns the count as it stood before the access and then lowers it by one when it was non-zero. A write acts as V: it raises the count by one, stopping at the all-ones value. One P view blocks and the other only polls. A blocking P that finds the count at zero returns a blocked response and records the requesting thread in a blocked mask. The next V releases every recorded thread through a one-cycle wake pulse that carries a wake mask.

The remaining views give a raw look at the count, a tag word shaped like that of a neighbouring queue cell, and the two queue views, which are inert on a semaphore cell.

Requests arrive on two valid/ready channels: a write channel and a read channel. Read results leave on a valid/ready response channel. The write channel never stalls. The read channel is held off while a write is offered, and also while a response is waiting that the consumer is not yet taking. A held response keeps its data stable until it is taken. The blocked mask and the wake signals are plain outputs.

Top module: `sem_cell`

## Requirements
- R1: A read in view 4 (blocking P) or view 5 (polling P) with a non-zero count returns that count, zero-extended in the low bits of the response, with the blocked flag clear. The count is one lower afterwards.
- R2: A view-4 read while the count is zero returns data 0 with the blocked flag set. It sets the bit of the requesting thread ID in the blocked mask and leaves the count at zero.
- R3: A view-5 read while the count is zero returns data 0 with the blocked flag clear. The blocked mask and the count are unchanged.
- R4: A write in view 4 or view 5 ignores its data and raises the count by one. The count stays put when it is already all ones (0xFFFF at the default width).
- R5: In the cycle after a view-4 or view-5 write is accepted, wake_mask equals the blocked mask from before the write, and wake_pulse is high exactly when that mask was non-zero. The blocked mask is then all zero. Outside that cycle, wake_pulse is low.
- R6: A view-0 read returns the count without changing it. A view-0 write changes nothing.
- R7: A view-1 write loads three tag flags from data bit 16, bit 1 and bit 0. A view-1 read returns those flags at the same three bit positions, with every other bit zero.
- R8: A read in view 2 or 3 returns zero, and a write in view 2 or 3 changes nothing. A read in view 6 or 7 returns all ones and leaves the count unchanged.
- R9: After reset the count, the tag flags, the blocked mask, wake_pulse, wake_mask and rsp_valid are all zero.
- R10: wr_ready is always high, and rd_ready is low whenever wr_valid is high. As a result, a V and a P offered in the same cycle take effect write first.
- R11: While rsp_valid is high and rsp_ready is low, rd_ready is low, and rsp_valid and rsp_data hold their values. A read offered during that time has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write request taken (always high) |
| wr_view | input | 3 | View code of the write |
| wr_data | input | DATA_W | Write data (used by view 1 only) |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request taken |
| rd_view | input | 3 | View code of the read |
| rd_tid | input | TID_W | Thread ID of the reader |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Read response data |
| rsp_blocked | output | 1 | Reader must wait for a wake |
| blocked_mask | output | NTHR | Threads waiting on this cell |
| wake_pulse | output | 1 | One-cycle release of waiting threads |
| wake_mask | output | NTHR | Threads released by the last V |

## Verification
The hardest situation to reach is a P that collides with a V, or a P that sits behind a stalled response. In both cases the count must be changed only by the request that actually wins the handshake. The bench offers a V and a P in the same cycle with the count at zero. It expects the P to return 1, which shows that the write was applied first. It also keeps rsp_ready low while a polling P waits at the read port. Once the port opens, that P must still see the count that was there before it arrived. Saturation is reached by building the bench with a 4-bit count and sweeping V past the top.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
  localparam logic [2:0] V_RAW   = 3'd0;
  localparam logic [2:0] V_TAG   = 3'd1;
  localparam logic [2:0] V_QWAIT = 3'd2;
  localparam logic [2:0] V_QPOLL = 3'd3;
  localparam logic [2:0] V_PWAIT = 3'd4;
  localparam logic [2:0] V_PPOLL = 3'd5;

  localparam int TAG_T_BIT = 16;
  localparam int TAG_F_BIT = 1;
  localparam int TAG_E_BIT = 0;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } tag_t;
endpackage

// File: rtl/sem_cell_arb.sv
module sem_cell_arb (
  input  logic wr_valid,
  input  logic rd_valid,
  input  logic rsp_valid,
  input  logic rsp_ready,
  output logic wr_ready,
  output logic rd_ready,
  output logic wr_fire,
  output logic rd_fire
);
  // writes never stall; a read waits for a free response slot and no write
  assign wr_ready = 1'b1;
  assign rd_ready = !wr_valid && (!rsp_valid || rsp_ready);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
endmodule

// File: rtl/sem_cell_core.sv
module sem_cell_core
  import sem_cell_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NTHR   = 8,
  parameter int DATA_W = 64,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [2:0]        wr_view,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_fire,
  input  logic [2:0]        rd_view,
  input  logic [TID_W-1:0]  rd_tid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_blocked,
  output logic [CNT_W-1:0]  count,
  output logic [NTHR-1:0]   blk_mask,
  output logic              wake,
  output logic [NTHR-1:0]   wake_set
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  tag_t             tag_q, tag_n;
  logic [NTHR-1:0]  blk_q, blk_n;
  logic             wake_q, wake_n;
  logic [NTHR-1:0]  wakem_q, wakem_n;

  always_comb begin
    cnt_n       = cnt_q;
    tag_n       = tag_q;
    blk_n       = blk_q;
    wake_n      = 1'b0;
    wakem_n     = '0;
    res_data    = '0;
    res_blocked = 1'b0;

    if (wr_fire) begin
      case (wr_view)
        V_PWAIT, V_PPOLL: begin
          if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
          wake_n  = |blk_q;
          wakem_n = blk_q;
          blk_n   = '0;
        end
        V_TAG: begin
          tag_n.t = wr_data[TAG_T_BIT];
          tag_n.f = wr_data[TAG_F_BIT];
          tag_n.e = wr_data[TAG_E_BIT];
        end
        default: ;
      endcase
    end

    if (rd_fire) begin
      case (rd_view)
        V_RAW: res_data = DATA_W'(cnt_q);
        V_TAG: begin
          res_data[TAG_T_BIT] = tag_q.t;
          res_data[TAG_F_BIT] = tag_q.f;
          res_data[TAG_E_BIT] = tag_q.e;
        end
        V_QWAIT, V_QPOLL: res_data = '0;
        V_PWAIT, V_PPOLL: begin
          if (cnt_q != '0) begin
            res_data = DATA_W'(cnt_q);
            cnt_n    = cnt_q - 1'b1;
          end else if (rd_view == V_PWAIT) begin
            res_blocked   = 1'b1;
            blk_n[rd_tid] = 1'b1;
          end
        end
        default: res_data = '1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tag_q   <= '0;
      blk_q   <= '0;
      wake_q  <= 1'b0;
      wakem_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      tag_q   <= tag_n;
      blk_q   <= blk_n;
      wake_q  <= wake_n;
      wakem_q <= wakem_n;
    end
  end

  assign count    = cnt_q;
  assign blk_mask = blk_q;
  assign wake     = wake_q;
  assign wake_set = wakem_q;
endmodule

// File: rtl/sem_cell_rsp.sv
module sem_cell_rsp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_blocked,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_blocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_blocked <= 1'b0;
    end else if (load) begin
      rsp_valid   <= 1'b1;
      rsp_data    <= ld_data;
      rsp_blocked <= ld_blocked;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int CNT_W  = 16,
  parameter int NTHR   = 8,
  parameter int DATA_W = 64,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [2:0]        wr_view,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [2:0]        rd_view,
  input  logic [TID_W-1:0]  rd_tid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_blocked,
  output logic [NTHR-1:0]   blocked_mask,
  output logic              wake_pulse,
  output logic [NTHR-1:0]   wake_mask
);
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] res_data;
  logic              res_blocked;
  logic [CNT_W-1:0]  sem_count;

  sem_cell_arb u_arb (
    .wr_valid (wr_valid),
    .rd_valid (rd_valid),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .wr_ready (wr_ready),
    .rd_ready (rd_ready),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  sem_cell_core #(.CNT_W(CNT_W), .NTHR(NTHR), .DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_view    (wr_view),
    .wr_data    (wr_data),
    .rd_fire    (rd_fire),
    .rd_view    (rd_view),
    .rd_tid     (rd_tid),
    .res_data   (res_data),
    .res_blocked(res_blocked),
    .count      (sem_count),
    .blk_mask   (blocked_mask),
    .wake       (wake_pulse),
    .wake_set   (wake_mask)
  );

  sem_cell_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (rd_fire),
    .ld_data    (res_data),
    .ld_blocked (res_blocked),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_blocked(rsp_blocked)
  );
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
  parameter int CNT_W  = 16,
  parameter int NTHR   = 8,
  parameter int DATA_W = 64,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [2:0]        wr_view,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [2:0]        rd_view,
  input logic [TID_W-1:0]  rd_tid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_blocked,
  input logic [NTHR-1:0]   blocked_mask,
  input logic              wake_pulse,
  input logic [CNT_W-1:0]  sem_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic wr_pv, rd_pv;
  assign wr_pv = wr_valid && wr_ready && (wr_view == 3'd4 || wr_view == 3'd5);
  assign rd_pv = rd_valid && rd_ready && (rd_view == 3'd4 || rd_view == 3'd5);

  AST_P_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pv && sem_count != '0 |=> rsp_data == DATA_W'($past(sem_count)) && !rsp_blocked
                                 && sem_count == $past(sem_count) - 1'b1); // R1

  AST_P_BLOCK_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pv && rd_view == 3'd4 && sem_count == '0 |=> rsp_blocked && blocked_mask[$past(rd_tid)]
                                                    && sem_count == '0); // R2

  AST_V_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pv && sem_count == CMAX |=> sem_count == CMAX); // R4

  AST_V_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pv |=> blocked_mask == '0 && wake_pulse == $past(|blocked_mask)); // R5

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready && !rd_ready); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R11
endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .NTHR(NTHR), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_view     (wr_view),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_view     (rd_view),
  .rd_tid      (rd_tid),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_blocked (rsp_blocked),
  .blocked_mask(blocked_mask),
  .wake_pulse  (wake_pulse),
  .sem_count   (sem_count)
);

// File: tb/test_sem_cell.sv
`timescale 1ns/1ps
module test_sem_cell;
  localparam int CW = 4;
  localparam int NT = 4;
  localparam int DW = 64;
  localparam int TW = 2;
  localparam int CMAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [2:0]    wr_view = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic [2:0]    rd_view = '0;
  logic [TW-1:0] rd_tid = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          rsp_blocked;
  logic [NT-1:0] blocked_mask;
  logic          wake_pulse;
  logic [NT-1:0] wake_mask;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 1'b0;

  int            mcnt;
  logic [NT-1:0] mblk;
  logic [DW-1:0] rdat;
  logic          rblk;

  always #5 clk = ~clk;

  sem_cell #(.CNT_W(CW), .NTHR(NT), .DATA_W(DW)) i_sem_cell (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_view(wr_view), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_view(rd_view), .rd_tid(rd_tid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_blocked(rsp_blocked), .blocked_mask(blocked_mask),
    .wake_pulse(wake_pulse), .wake_mask(wake_mask)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      summary();
    end
  end

  task automatic do_wr(logic [2:0] v, logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_view = v; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_rd(logic [2:0] v, logic [TW-1:0] t, output logic [DW-1:0] d,
                       output logic b);
    @(negedge clk);
    rd_valid = 1'b1; rd_view = v; rd_tid = t; rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R11 rsp_valid", DW'(rsp_valid), DW'(1));
    d = rsp_data;
    b = rsp_blocked;
  endtask

  task automatic raw_is(string req, int exp);
    logic [DW-1:0] d;
    logic b;
    do_rd(3'd0, '0, d, b);
    chk(req, d, DW'(exp));
  endtask

  initial begin
    mcnt = 0;
    mblk = '0;
    repeat (3) @(negedge clk);
    chk("R9 rsp_valid", DW'(rsp_valid), 0);
    chk("R9 wake_pulse", DW'(wake_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 blocked_mask", DW'(blocked_mask), 0);
    chk("R9 wake_mask", DW'(wake_mask), 0);
    raw_is("R9 count", 0);
    do_rd(3'd1, '0, rdat, rblk);
    chk("R9 tag", rdat, 0);

    // R3 polling P at zero
    do_rd(3'd5, 2'd1, rdat, rblk);
    chk("R3 data", rdat, 0);
    chk("R3 blocked", DW'(rblk), 0);
    chk("R3 mask", DW'(blocked_mask), 0);

    // R2 blocking P at zero from every thread
    for (int t = 0; t < NT; t++) begin
      do_rd(3'd4, TW'(t), rdat, rblk);
      mblk[t] = 1'b1;
      chk("R2 data", rdat, 0);
      chk("R2 blocked", DW'(rblk), 1);
      chk("R2 mask", DW'(blocked_mask), DW'(mblk));
    end
    raw_is("R2 count stays zero", 0);

    // R5 V releases all waiters
    do_wr(3'd5, 64'hDEAD_BEEF_0000_0007);
    mcnt = 1;
    chk("R5 wake_pulse", DW'(wake_pulse), 1);
    chk("R5 wake_mask", DW'(wake_mask), DW'(mblk));
    chk("R5 mask cleared", DW'(blocked_mask), 0);
    mblk = '0;
    @(negedge clk);
    chk("R5 pulse one cycle", DW'(wake_pulse), 0);

    // R4 sweep V through saturation, data ignored
    for (int k = 1; k <= 19; k++) begin
      do_wr((k % 2 == 0) ? 3'd4 : 3'd5, DW'(k) * 64'h1111);
      if (mcnt < CMAX) mcnt++;
      chk("R5 no pulse when none wait", DW'(wake_pulse), 0);
      raw_is("R4 count after V", mcnt);
    end

    // R6 raw write ignored
    do_wr(3'd0, 64'h0);
    raw_is("R6 raw write ignored", mcnt);

    // R8 queue views inert, undefined views all ones
    for (int v = 2; v <= 3; v++) begin
      do_wr(3'(v), 64'h5);
      do_rd(3'(v), '0, rdat, rblk);
      chk("R8 queue view read", rdat, 0);
      raw_is("R8 count unchanged", mcnt);
    end
    for (int v = 6; v <= 7; v++) begin
      do_rd(3'(v), '0, rdat, rblk);
      chk("R8 undefined view read", rdat, '1);
      raw_is("R8 count unchanged", mcnt);
    end

    // R1 sweep P down to zero, alternating views
    for (int k = 0; k < CMAX; k++) begin
      do_rd((k % 2 == 0) ? 3'd4 : 3'd5, TW'(k), rdat, rblk);
      chk("R1 old value", rdat, DW'(mcnt));
      chk("R1 not blocked", DW'(rblk), 0);
      mcnt--;
    end
    raw_is("R1 count at zero", 0);

    // R7 tag flag sweep with junk in other bits
    for (int v = 0; v < 8; v++) begin
      logic [DW-1:0] w;
      logic [DW-1:0] e;
      e = '0;
      e[16] = v[2]; e[1] = v[1]; e[0] = v[0];
      w = e | 64'hFFFF_FFFF_FFFE_FFFC;
      do_wr(3'd1, w);
      do_rd(3'd1, '0, rdat, rblk);
      chk("R7 tag read", rdat, e);
    end
    raw_is("R7 count untouched", 0);

    // R10 simultaneous V and P: write goes first
    @(negedge clk);
    wr_valid = 1'b1; wr_view = 3'd4; wr_data = '0;
    rd_valid = 1'b1; rd_view = 3'd5; rd_tid = '0; rsp_ready = 1'b1;
    #1;
    chk("R10 wr_ready", DW'(wr_ready), 1);
    chk("R10 rd_ready low", DW'(rd_ready), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R10 read still waiting", DW'(rsp_valid), 0);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R10 P sees V", rsp_data, 1);
    raw_is("R10 count", 0);

    // R11 back-pressure
    do_wr(3'd5, '0);
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_view = 3'd0;
    @(negedge clk);
    rd_view = 3'd5;
    for (int k = 0; k < 3; k++) begin
      chk("R11 held valid", DW'(rsp_valid), 1);
      chk("R11 held data", rsp_data, 1);
      chk("R11 rd_ready low", DW'(rd_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R11 stalled P saw untouched count", rsp_data, 1);
    raw_is("R11 count after P", 0);

    done = 1'b1;
    summary();
  end
endmodule